// File: doc/BRIEF.md
# Partial-Tag Way Filter

This block sits next to a set-associative cache and keeps, for every set and every way, a short slice of the stored tag (its lowest bits) together with a valid bit, in a small register array of its own. When a lookup arrives, the block reads the slices of all ways of the addressed set at once and compares each with the same low bits of the lookup tag. The result is one enable per way, produced combinationally in the cycle of the lookup, ahead of the main tag and data arrays. A way whose slice differs, or whose entry is not valid, cannot hold the line, so its full tag and data arrays are left idle.

A matching slice does not mean a hit. It only allows the full tag comparison to take place in that way, and several ways may pass at once. When no way passes, an early-miss flag is raised in the same cycle so the refill path can start immediately. Each fill names a set, a way and the new tag. It stores the low tag bits into the filter at the next clock edge and marks the entry valid.

Top module: `ptag_halt_filter`

## Requirements
- R1: While rst_n is low at a clock edge, every entry becomes invalid. After reset, any lookup gives way_enable = 0 and early_miss = 1 until a fill writes the set.
- R2: Bit w of way_enable is 1 exactly when lookup_valid is 1, entry (lookup_index, w) is valid, and its stored slice equals lookup_tag[3:0]. Bit w of way_enable belongs to way w.
- R3: way_enable and early_miss are combinational functions of the lookup inputs and the stored state, and are valid in the same cycle as the lookup.
- R4: early_miss is 1 exactly when lookup_valid is 1 and way_enable is 0. While lookup_valid is 0, way_enable is 0 and early_miss is 0.
- R5: A fill (fill_valid = 1) stores fill_tag[3:0] as the slice of way fill_way (binary, 0 to 3) in set fill_index and marks it valid at the next rising edge. Other ways and other sets keep their contents. A second fill to the same entry replaces the slice.
- R6: When a fill and a lookup target the same set in the same cycle, the lookup sees the contents from before the fill. The fill is visible to the next lookup.
- R7: Several ways may be enabled together when their slices are equal. An enable only permits the full compare and is not a hit.
- R8: Bits above bit 3 of lookup_tag and fill_tag have no effect on way_enable or early_miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookup_valid | input | 1 | A lookup is presented this cycle |
| lookup_index | input | 6 | Set addressed by the lookup |
| lookup_tag | input | 20 | Full tag of the lookup address |
| fill_valid | input | 1 | Write a new tag slice this cycle |
| fill_index | input | 6 | Set being filled |
| fill_way | input | 2 | Way being filled, binary |
| fill_tag | input | 20 | Full tag of the filled line |
| way_enable | output | 4 | Per-way permission to activate the full arrays |
| early_miss | output | 1 | Lookup valid with no way enabled |

## Verification
The two functions that can meet in one cycle are the slice write of a fill and the read of a lookup to the same set. The bench provokes this by presenting a lookup and a fill to the same set, way and low tag bits in one cycle. It expects the old result (a miss if the entry was empty) in that cycle and the new way's enable in the next. Random traffic with frequent set collisions repeats the case, and each cycle is judged against a bench-side model that takes fills into effect only after the lookup of that cycle.

// File: rtl/ptag_pkg.sv
// Package: default geometry shared by the partial-tag way filter and its bench.
// Assumes nothing beyond being compiled first.
package ptag_pkg;
    localparam int DEF_WAYS   = 4;
    localparam int DEF_SETS   = 64;
    localparam int DEF_TAG_W  = 20;
    localparam int DEF_PTAG_W = 4;
endpackage

// File: rtl/ptag_way_bank.sv
// Module: storage of tag slices and valid bits for one way across all sets.
// Assumes one write and one asynchronous read per cycle. A read of the entry
// being written returns the old contents. Reset clears only the valid bits.
module ptag_way_bank #(
    parameter int SETS   = ptag_pkg::DEF_SETS,
    parameter int PTAG_W = ptag_pkg::DEF_PTAG_W,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PTAG_W-1:0] wr_slice,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PTAG_W-1:0] rd_slice
);
    logic [SETS-1:0]   valid_q;
    logic [PTAG_W-1:0] slice_q [SETS];

    // Purpose: clear valid bits on reset, set the written entry on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Purpose: store the written slice; contents behind a clear valid bit are don't-care.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            slice_q[wr_idx] <= wr_slice;
        end
    end

    // Purpose: read the addressed entry in the same cycle.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_slice = slice_q[rd_idx];
    end
endmodule

// File: rtl/ptag_way_match.sv
// Module: decides whether one way may take part in the full tag compare.
// Assumes the stored entry has already been read for the lookup set.
module ptag_way_match #(
    parameter int PTAG_W = ptag_pkg::DEF_PTAG_W
) (
    input  logic              req,
    input  logic              entry_valid,
    input  logic [PTAG_W-1:0] entry_slice,
    input  logic [PTAG_W-1:0] req_slice,
    output logic              enable
);
    // Purpose: enable the way only on a valid entry whose slice equals the request.
    always_comb begin
        enable = req && entry_valid && (entry_slice == req_slice);
    end
endmodule

// File: rtl/ptag_halt_filter.sv
// Module: partial-tag way filter. Holds low tag bits per set and way and,
// in the lookup cycle, gives per-way enables and an early-miss flag.
// Assumes fill_way is in range and that at most one fill arrives per cycle.
module ptag_halt_filter #(
    parameter int WAYS   = ptag_pkg::DEF_WAYS,
    parameter int SETS   = ptag_pkg::DEF_SETS,
    parameter int TAG_W  = ptag_pkg::DEF_TAG_W,
    parameter int PTAG_W = ptag_pkg::DEF_PTAG_W,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lookup_valid,
    input  logic [IDX_W-1:0] lookup_index,
    input  logic [TAG_W-1:0] lookup_tag,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_index,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    output logic [WAYS-1:0]  way_enable,
    output logic             early_miss
);
    logic [PTAG_W-1:0] req_slice;
    logic [PTAG_W-1:0] new_slice;
    logic              unused_upper;

    // Purpose: take the low tag bits that the filter keeps.
    always_comb begin
        req_slice    = lookup_tag[PTAG_W-1:0];
        new_slice    = fill_tag[PTAG_W-1:0];
        unused_upper = ^{lookup_tag[TAG_W-1:PTAG_W], fill_tag[TAG_W-1:PTAG_W]};
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic              wr_hit;
        logic              ent_valid;
        logic [PTAG_W-1:0] ent_slice;

        // Purpose: route the fill to this way only.
        always_comb begin
            wr_hit = fill_valid && (fill_way == WAY_W'(w));
        end

        ptag_way_bank #(.SETS(SETS), .PTAG_W(PTAG_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_hit),
            .wr_idx   (fill_index),
            .wr_slice (new_slice),
            .rd_idx   (lookup_index),
            .rd_valid (ent_valid),
            .rd_slice (ent_slice)
        );

        ptag_way_match #(.PTAG_W(PTAG_W)) u_match (
            .req         (lookup_valid),
            .entry_valid (ent_valid),
            .entry_slice (ent_slice),
            .req_slice   (req_slice),
            .enable      (way_enable[w])
        );
    end

    // Purpose: flag a certain miss as soon as no way survives.
    always_comb begin
        early_miss = lookup_valid && (way_enable == '0);
    end
endmodule

// File: rtl/ptag_halt_filter_chk.sv
// Module: assertion checker for the partial-tag way filter, bound to the top.
// Assumes the same parameters as the instance it is bound to.
module ptag_halt_filter_chk #(
    parameter int WAYS   = ptag_pkg::DEF_WAYS,
    parameter int SETS   = ptag_pkg::DEF_SETS,
    parameter int PTAG_W = ptag_pkg::DEF_PTAG_W,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lookup_valid,
    input logic [IDX_W-1:0]  lookup_index,
    input logic [PTAG_W-1:0] lookup_slice,
    input logic              fill_valid,
    input logic [IDX_W-1:0]  fill_index,
    input logic [WAY_W-1:0]  fill_way,
    input logic [PTAG_W-1:0] fill_slice,
    input logic [WAYS-1:0]   way_enable,
    input logic              early_miss
);
    // R4: no lookup means no enables and no miss
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |-> (way_enable == '0) && !early_miss);

    // R4: miss flag and enables are mutually exclusive
    assert_miss_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        early_miss |-> lookup_valid && (way_enable == '0));

    // R4: a lookup with no enabled way raises the miss flag
    assert_miss_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && (way_enable == '0)) |-> early_miss);

    // R6: a fill is visible to a matching lookup in the next cycle
    assert_fill_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_valid) && lookup_valid
         && (lookup_index == $past(fill_index))
         && (lookup_slice == $past(fill_slice)))
        |-> way_enable[$past(fill_way)]);

    // R2: at most the ways of a live lookup are enabled
    for (genvar w = 0; w < WAYS; w++) begin : g_chk
        assert_en_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
            way_enable[w] |-> lookup_valid);
    end
endmodule

bind ptag_halt_filter ptag_halt_filter_chk #(
    .WAYS(WAYS), .SETS(SETS), .PTAG_W(PTAG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .lookup_index (lookup_index),
    .lookup_slice (lookup_tag[PTAG_W-1:0]),
    .fill_valid   (fill_valid),
    .fill_index   (fill_index),
    .fill_way     (fill_way),
    .fill_slice   (fill_tag[PTAG_W-1:0]),
    .way_enable   (way_enable),
    .early_miss   (early_miss)
);

// File: tb/ptag_halt_filter_test.sv
// Bench: scoreboard for the partial-tag way filter. A driver task applies one
// cycle of stimulus and queues the expected outputs from a bench-side model;
// a monitor compares them mid-cycle.
module ptag_halt_filter_test;
    localparam int WAYS = 4;
    localparam int SETS = 64;
    localparam int TW   = 20;

    typedef struct {
        logic [WAYS-1:0] en;
        logic            miss;
        string           tag_r;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lookup_valid = 1'b0;
    logic [5:0]      lookup_index = '0;
    logic [TW-1:0]   lookup_tag = '0;
    logic            fill_valid = 1'b0;
    logic [5:0]      fill_index = '0;
    logic [1:0]      fill_way = '0;
    logic [TW-1:0]   fill_tag = '0;
    logic [WAYS-1:0] way_enable;
    logic            early_miss;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    logic       m_val [SETS][WAYS];
    logic [3:0] m_slc [SETS][WAYS];

    always #10 clk = ~clk;

    ptag_halt_filter uut (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid(lookup_valid), .lookup_index(lookup_index), .lookup_tag(lookup_tag),
        .fill_valid(fill_valid), .fill_index(fill_index), .fill_way(fill_way), .fill_tag(fill_tag),
        .way_enable(way_enable), .early_miss(early_miss)
    );

    function automatic logic [WAYS-1:0] model_en(logic lv, logic [5:0] idx, logic [TW-1:0] t);
        logic [WAYS-1:0] e = '0;
        for (int w = 0; w < WAYS; w++)
            e[w] = lv && m_val[idx][w] && (m_slc[idx][w] == t[3:0]);
        return e;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_val[s][w] = 1'b0;
    endtask

    // One clock of stimulus; expected outputs use the state before this cycle's fill.
    task automatic step(logic lv, logic [5:0] li, logic [TW-1:0] lt,
                        logic fv, logic [5:0] fi, logic [1:0] fw, logic [TW-1:0] ft,
                        string rq);
        exp_t x;
        @(negedge clk);
        lookup_valid = lv; lookup_index = li; lookup_tag = lt;
        fill_valid = fv; fill_index = fi; fill_way = fw; fill_tag = ft;
        x.en    = model_en(lv, li, lt);
        x.miss  = lv && (x.en == '0);
        x.tag_r = rq;
        sb_q.push_back(x);
        if (fv) begin
            m_val[fi][fw] = 1'b1;
            m_slc[fi][fw] = ft[3:0];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lookup_valid = 1'b0; fill_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Monitor: compare queued expectations a quarter period after the driving edge.
    initial begin
        exp_t x;
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                x = sb_q.pop_front();
                total++;
                if (way_enable !== x.en || early_miss !== x.miss) begin
                    bad++;
                    $display("FAIL %s: en=%b miss=%b expected en=%b miss=%b",
                             x.tag_r, way_enable, early_miss, x.en, x.miss);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: timeout actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'h1ACE_5EED;
        model_clear();
        do_reset();
        // R1: after reset every lookup misses
        step(1, 6'd0,  20'h00000, 0, 0, 0, 0, "R1");
        step(1, 6'd63, 20'hFFFFF, 0, 0, 0, 0, "R1");
        // R4: idle lookup gives no enables, no miss
        step(0, 6'd3,  20'h00003, 0, 0, 0, 0, "R4");
        // R5: fill then lookup, same cycle result per R3
        step(0, 0, 0, 1, 6'd10, 2'd1, 20'h12345, "R5");
        step(1, 6'd10, 20'h00005, 0, 0, 0, 0, "R5");
        step(1, 6'd11, 20'h00005, 0, 0, 0, 0, "R5 other set");
        // R2: differing slice is halted
        step(1, 6'd10, 20'h00006, 0, 0, 0, 0, "R2");
        // R8: upper bits ignored
        step(1, 6'd10, 20'hABCD5, 0, 0, 0, 0, "R8");
        // R7: two ways holding the same slice both enabled
        step(0, 0, 0, 1, 6'd10, 2'd3, 20'hFFFF5, "R7");
        step(1, 6'd10, 20'h77775, 0, 0, 0, 0, "R7");
        // R5: overwrite replaces the slice
        step(0, 0, 0, 1, 6'd10, 2'd1, 20'h0000C, "R5 overwrite");
        step(1, 6'd10, 20'h00005, 0, 0, 0, 0, "R5 overwrite");
        step(1, 6'd10, 20'h0000C, 0, 0, 0, 0, "R5 overwrite");
        // R6: fill and lookup to one set in one cycle, old contents seen
        step(1, 6'd20, 20'h0000A, 1, 6'd20, 2'd2, 20'h0000A, "R6 same cycle");
        step(1, 6'd20, 20'h0000A, 0, 0, 0, 0, "R6 next cycle");
        step(1, 6'd20, 20'h0000B, 1, 6'd20, 2'd2, 20'h0000B, "R6 same cycle replace");
        step(1, 6'd20, 20'h0000B, 0, 0, 0, 0, "R6 next cycle replace");
        // R3: random traffic with narrow index range to force collisions
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0], {4'd0, lfsr[2:1]}, {lfsr[19:4], 1'b0, lfsr[7:5]},
                 lfsr[8], {4'd0, lfsr[10:9]}, lfsr[12:11], {lfsr[31:16], 1'b0, lfsr[15:13]},
                 "R3 random");
        end
        // R1: reset clears filled entries
        do_reset();
        step(1, 6'd10, 20'h0000C, 0, 0, 0, 0, "R1 after refill reset");
        step(1, 6'd20, 20'h0000B, 0, 0, 0, 0, "R1 after refill reset");
        @(negedge clk);
        lookup_valid = 1'b0; fill_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule